// File: doc/BRIEF.md
# I2C Slave Register Interface for a 10-Bit Current-Sink DAC

This block is the digital front end of a 10-bit current-output DAC. It listens on a two-wire I2C-compatible bus, recognises its own address and accepts a two-byte frame. The frame carries a soft power-down flag and a 10-bit code. Once a whole frame has been accepted and acknowledged, the frame is copied into the DAC register. The analog converter downstream reads the code and the effective power-down level directly from this block.

SCL and SDA are sampled with a fast system clock. Both lines pass through a synchronizer and a run-length glitch filter. Start and stop conditions and clock edges are found on the filtered lines. The slave drives SDA only through an active-high pull-low enable, which the pad turns into an open-drain output. A read returns the held frame in the same bit order as a write. After a read completes, the held frame is cleared. A hardware power-down pin overrides the soft flag without passing through any clocked logic.

Top module: `sink_dac_bus_slave`

## Requirements
- R1: After reset `dac_code` is 0, `pwr_down_eff` follows `pd_pin` only, `sda_pull` is 0, and the held frame is all zeros, so a read returns 0x0000.
- R2: The device answers any 7-bit address whose upper five bits are 00011; the two low address bits are ignored. The eighth bit of the address byte is R/W (0 = write, 1 = read). Other addresses get no acknowledge, and the data bytes that follow have no effect.
- R3: The slave acknowledges by raising `sda_pull` across the ninth SCL clock after a matching address and after each of the two write data bytes. It only starts pulling while the filtered SCL is low.
- R4: Frame bits arrive high byte first, MSB first. In the 16-bit frame, bit 15 is the soft power-down flag and bits 13..4 are the DAC code D9..D0. Bits 14 and 3..0 are ignored.
- R5: The DAC register, the soft flag and the held frame change only at the end of the acknowledge of the second write data byte. A stop or start that arrives earlier leaves all three unchanged.
- R6: A read returns the held frame as two bytes: bits 15..8 first, then bits 7..0, each MSB first.
- R7: After both read bytes have been transferred, the held frame becomes 0x0000. The DAC register is not changed by the read.
- R8: `pwr_down_eff` is the OR of `pd_pin` and the soft flag. The pin path is combinational, with no clock on it.
- R9: A pulse on SCL or SDA lasting fewer than FILT_CYCLES system clocks (12, which is 60 ns at 200 MHz) is ignored.
- R10: When the master answers the first read byte with a NACK, the slave releases SDA and returns to idle. The held frame is kept, so a later full read still returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| scl_in | input | 1 | Bus clock line level from the pad |
| sda_in | input | 1 | Bus data line level from the pad |
| pd_pin | input | 1 | Hardware power-down request, active high |
| sda_pull | output | 1 | Open-drain enable; 1 pulls SDA low |
| dac_code | output | 10 | Code for the converter |
| pwr_down_eff | output | 1 | Effective power-down: pin OR soft flag |

## Verification
The hardest situations to reach are a sub-filter spike on SDA while SCL is high, and a frame cut short by a start or stop. A spike of the first kind would look like a stop in the middle of a data bit. The bench master adds a spike of a fixed width in system clocks inside the high phase of a chosen bit. It does this once on SDA and once on SCL, and then checks that the frame still commits normally. For aborts, the bench stops after one data byte, and separately issues a repeated start followed by a foreign address. After each abort it reads back the held frame to show that nothing moved.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK_ADDR,
      ST_WDATA,
      ST_ACK_WDATA,
      ST_RDATA,
      ST_ACK_RDATA
   } eng_state_t;
endpackage

// File: rtl/sdac_glitch_filter.sv
module sdac_glitch_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYCLES = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_raw,
   output logic line_q
);
   localparam int CNT_W = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sync_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_raw};
   end
   assign sync_bit = sync_q[SYNC_STAGES-1];

   generate
      if (FILT_CYCLES <= 1) begin : g_bypass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line_q <= 1'b1;
            else        line_q <= sync_bit;
         end
      end else begin : g_count
         logic [CNT_W-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q  <= '0;
               line_q <= 1'b1;
            end else if (sync_bit == line_q) begin
               run_q <= '0;
            end else if (run_q == CNT_W'(FILT_CYCLES - 1)) begin
               line_q <= sync_bit;
               run_q  <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end

         // R9: a new filtered level must have been present on the synchronized line for at least two samples
         assert_filter_settled_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(line_q) |-> ($past(sync_bit, 1) == line_q && $past(sync_bit, 2) == line_q));
      end
   endgenerate
endmodule

// File: rtl/sdac_bus_events.sv
module sdac_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_f;
         sda_p <= sda_f;
      end
   end

   assign scl_rise = scl_f & ~scl_p;
   assign scl_fall = ~scl_f & scl_p;
   assign start_ev = scl_f & scl_p & sda_p & ~sda_f;
   assign stop_ev  = scl_f & scl_p & ~sda_p & sda_f;
endmodule

// File: rtl/sdac_engine.sv
module sdac_engine #(
   parameter int         FRAME_W  = 16,
   parameter int         CODE_W   = 10,
   parameter int         CODE_LSB = 4,
   parameter int         PD_BIT   = 15,
   parameter int         ADDR_W   = 5,
   parameter logic [4:0] ADDR_VAL = 5'b00011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_hi,
   input  logic              sda_bit,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_ev,
   input  logic              stop_ev,
   output logic              sda_pull,
   output logic [CODE_W-1:0] dac_code,
   output logic              soft_pd
);
   import sdac_pkg::*;

   localparam int FRAME_BYTES = FRAME_W / BYTE_W;
   localparam int IDX_W       = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

   eng_state_t         st;
   logic [2:0]         bit_cnt;
   logic               byte_full;
   logic [BYTE_W-1:0]  sh_in, sh_out, next_rd;
   logic [IDX_W-1:0]   byte_idx;
   logic [FRAME_W-1:0] frame_acc, in_reg;
   logic               rw_q, nack_q, pull_q;
   logic               addr_hit;

   assign addr_hit = (sh_in[BYTE_W-1 -: ADDR_W] == ADDR_VAL[ADDR_W-1:0]);
   assign next_rd  = BYTE_W'(in_reg >> (FRAME_W - BYTE_W * (int'(byte_idx) + 2)));
   assign sda_pull = pull_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         bit_cnt   <= '0;
         byte_full <= 1'b0;
         sh_in     <= '0;
         sh_out    <= '0;
         byte_idx  <= '0;
         frame_acc <= '0;
         in_reg    <= '0;
         rw_q      <= 1'b0;
         nack_q    <= 1'b0;
         pull_q    <= 1'b0;
         dac_code  <= '0;
         soft_pd   <= 1'b0;
      end else if (start_ev) begin
         st        <= ST_ADDR;
         bit_cnt   <= '0;
         byte_full <= 1'b0;
         byte_idx  <= '0;
         pull_q    <= 1'b0;
      end else if (stop_ev) begin
         st        <= ST_IDLE;
         byte_full <= 1'b0;
         pull_q    <= 1'b0;
      end else begin
         case (st)
            ST_ADDR, ST_WDATA: begin
               if (scl_rise) begin
                  sh_in   <= {sh_in[BYTE_W-2:0], sda_bit};
                  bit_cnt <= bit_cnt + 1'b1;
                  if (bit_cnt == 3'd7) byte_full <= 1'b1;
               end else if (scl_fall && byte_full) begin
                  byte_full <= 1'b0;
                  bit_cnt   <= '0;
                  if (st == ST_ADDR) begin
                     if (addr_hit) begin
                        rw_q   <= sh_in[0];
                        pull_q <= 1'b1;
                        st     <= ST_ACK_ADDR;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end else begin
                     frame_acc <= {frame_acc[FRAME_W-BYTE_W-1:0], sh_in};
                     pull_q    <= 1'b1;
                     st        <= ST_ACK_WDATA;
                  end
               end
            end
            ST_ACK_ADDR: begin
               if (scl_fall) begin
                  if (rw_q) begin
                     sh_out <= in_reg[FRAME_W-1 -: BYTE_W];
                     pull_q <= ~in_reg[FRAME_W-1];
                     st     <= ST_RDATA;
                  end else begin
                     pull_q <= 1'b0;
                     st     <= ST_WDATA;
                  end
               end
            end
            ST_ACK_WDATA: begin
               if (scl_fall) begin
                  pull_q <= 1'b0;
                  if (byte_idx == LAST_IDX) begin
                     in_reg   <= frame_acc;
                     dac_code <= frame_acc[CODE_LSB +: CODE_W];
                     soft_pd  <= frame_acc[PD_BIT];
                     st       <= ST_IDLE;
                  end else begin
                     byte_idx <= byte_idx + 1'b1;
                     st       <= ST_WDATA;
                  end
               end
            end
            ST_RDATA: begin
               if (scl_rise) begin
                  bit_cnt <= bit_cnt + 1'b1;
                  if (bit_cnt == 3'd7) byte_full <= 1'b1;
               end else if (scl_fall) begin
                  if (byte_full) begin
                     byte_full <= 1'b0;
                     bit_cnt   <= '0;
                     pull_q    <= 1'b0;
                     st        <= ST_ACK_RDATA;
                  end else begin
                     sh_out <= {sh_out[BYTE_W-2:0], 1'b0};
                     pull_q <= ~sh_out[BYTE_W-2];
                  end
               end
            end
            ST_ACK_RDATA: begin
               if (scl_rise) begin
                  nack_q <= sda_bit;
               end else if (scl_fall) begin
                  if (byte_idx == LAST_IDX) begin
                     in_reg <= '0;
                     st     <= ST_IDLE;
                  end else if (nack_q) begin
                     st <= ST_IDLE;
                  end else begin
                     byte_idx <= byte_idx + 1'b1;
                     sh_out   <= next_rd;
                     pull_q   <= ~next_rd[BYTE_W-1];
                     st       <= ST_RDATA;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R3: the line is held low throughout every acknowledge the slave gives
   assert_ack_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ACK_ADDR || st == ST_ACK_WDATA) |-> sda_pull);

   // R3: pulling begins only while the filtered clock is low
   assert_pull_on_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> !scl_hi);

   // R5: the DAC register moves only at the end of the final write acknowledge
   assert_commit_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dac_code) |-> ($past(st) == ST_ACK_WDATA && $past(scl_fall) && $past(byte_idx) == LAST_IDX));

   // R7: a completed two-byte read leaves the held frame empty
   assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == ST_ACK_RDATA && $past(scl_fall) && $past(byte_idx) == LAST_IDX) |-> in_reg == '0);

   // R10: an idle slave never holds the data line
   assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_pull);
endmodule

// File: rtl/sink_dac_bus_slave.sv
module sink_dac_bus_slave #(
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_CYCLES = 12,
   parameter int         FRAME_W     = 16,
   parameter int         CODE_W      = 10,
   parameter int         CODE_LSB    = 4,
   parameter int         PD_BIT      = 15,
   parameter int         ADDR_W      = 5,
   parameter logic [4:0] ADDR_VAL    = 5'b00011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic              pd_pin,
   output logic              sda_pull,
   output logic [CODE_W-1:0] dac_code,
   output logic              pwr_down_eff
);
   localparam int N_LINES = 2;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FRAME_W % 8 != 0 || FRAME_W < 16) begin : g_bad_frame
         $error("FRAME_W must be a whole number of bytes, two or more");
      end
      if (PD_BIT >= FRAME_W || CODE_LSB + CODE_W > PD_BIT) begin : g_bad_fields
         $error("code field must sit below the power-down bit inside the frame");
      end
      if (ADDR_W < 1 || ADDR_W > 5) begin : g_bad_addr
         $error("ADDR_W must be between 1 and 5");
      end
   endgenerate

   logic [N_LINES-1:0] raw_lines, filt_lines;
   logic scl_rise, scl_fall, start_ev, stop_ev, soft_pd;

   assign raw_lines = {sda_in, scl_in};

   generate
      for (genvar g = 0; g < N_LINES; g++) begin : g_line
         sdac_glitch_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_CYCLES(FILT_CYCLES)
         ) filt_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_raw(raw_lines[g]),
            .line_q  (filt_lines[g])
         );
      end
   endgenerate

   sdac_bus_events ev_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_f   (filt_lines[0]),
      .sda_f   (filt_lines[1]),
      .scl_rise(scl_rise),
      .scl_fall(scl_fall),
      .start_ev(start_ev),
      .stop_ev (stop_ev)
   );

   sdac_engine #(
      .FRAME_W (FRAME_W),
      .CODE_W  (CODE_W),
      .CODE_LSB(CODE_LSB),
      .PD_BIT  (PD_BIT),
      .ADDR_W  (ADDR_W),
      .ADDR_VAL(ADDR_VAL)
   ) eng_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_hi  (filt_lines[0]),
      .sda_bit (filt_lines[1]),
      .scl_rise(scl_rise),
      .scl_fall(scl_fall),
      .start_ev(start_ev),
      .stop_ev (stop_ev),
      .sda_pull(sda_pull),
      .dac_code(dac_code),
      .soft_pd (soft_pd)
   );

   assign pwr_down_eff = pd_pin | soft_pd;
endmodule

// File: tb/sink_dac_bus_slave_tb_top.sv
`timescale 1ns/1ps
module sink_dac_bus_slave_tb_top;
   localparam int Q  = 32;
   localparam int GL = 6;

   typedef struct {
      string       tag;
      logic [15:0] v;
   } item_t;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1, sda_m = 1'b1, pd_pin = 1'b0;
   logic       sda_pull, pwr_down_eff, sda_line;
   logic [9:0] dac_code;

   assign sda_line = sda_m & ~sda_pull;

   sink_dac_bus_slave dut_i (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .pd_pin(pd_pin),
      .sda_pull(sda_pull), .dac_code(dac_code), .pwr_down_eff(pwr_down_eff)
   );

   item_t       exp_q[$];
   logic [15:0] obs_q[$];
   int          n_checks = 0, n_errors = 0;
   logic [15:0] m_in = 16'h0;
   logic [9:0]  m_code = 10'h0;
   logic        m_spd = 1'b0;

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   endtask

   // scoreboard monitor: pairs each observation with the oldest expectation
   initial begin : monitor
      item_t       e;
      logic [15:0] o;
      forever begin
         @(negedge clk);
         while (obs_q.size() > 0) begin
            o = obs_q.pop_front();
            n_checks++;
            if (exp_q.size() == 0) begin
               n_errors++;
               $display("FAIL scoreboard underrun actual %h expected none", o);
            end else begin
               e = exp_q.pop_front();
               if (o !== e.v) begin
                  n_errors++;
                  $display("FAIL %s actual %h expected %h", e.tag, o, e.v);
               end
            end
         end
      end
   end

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog actual timeout expected completion");
      finish_run();
   end

   task automatic expect_item(input string tag, input logic [15:0] v);
      item_t it;
      it.tag = tag;
      it.v   = v;
      exp_q.push_back(it);
   endtask

   task automatic observe(input logic [15:0] v);
      obs_q.push_back(v);
   endtask

   task automatic qwait(input int n = 1);
      repeat (n * Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; scl_m = 1'b1; qwait();
      sda_m = 1'b0; qwait();
      scl_m = 1'b0; qwait();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; qwait();
      scl_m = 1'b1; qwait();
      sda_m = 1'b1; qwait(2);
   endtask

   // gmode 1 spikes SDA, gmode 2 spikes SCL, inside the high phase of bit gbit
   task automatic send_byte(input logic [7:0] b, input int gmode, input int gbit, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; qwait();
         scl_m = 1'b1;
         if (i == gbit && gmode != 0) begin
            repeat (Q/2) @(negedge clk);
            if (gmode == 1) sda_m = ~sda_m; else scl_m = ~scl_m;
            repeat (GL) @(negedge clk);
            if (gmode == 1) sda_m = ~sda_m; else scl_m = ~scl_m;
            repeat (2*Q - Q/2 - GL) @(negedge clk);
         end else begin
            qwait(2);
         end
         scl_m = 1'b0; qwait();
      end
      sda_m = 1'b1; qwait();
      scl_m = 1'b1; qwait();
      acked = !sda_line;
      qwait();
      scl_m = 1'b0; qwait();
   endtask

   task automatic recv_byte(input bit master_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         qwait();
         scl_m = 1'b1; qwait();
         b[i] = sda_line;
         qwait();
         scl_m = 1'b0; qwait();
      end
      sda_m = !master_ack; qwait();
      scl_m = 1'b1; qwait(2);
      scl_m = 1'b0; qwait();
      sda_m = 1'b1;
   endtask

   task automatic check_outputs(input string tg);
      expect_item({"R4 dac code ", tg}, {6'h0, m_code});
      observe({6'h0, dac_code});
      expect_item({"R8 effective power-down ", tg}, {15'h0, m_spd | pd_pin});
      observe({15'h0, pwr_down_eff});
      expect_item({"R3 line released ", tg}, 16'h0);
      observe({15'h0, sda_pull});
   endtask

   task automatic do_write(input logic [7:0] a, input logic [15:0] f, input bit hit,
                           input string tg, input int gmode = 0, input int gbit = -1);
      bit ak;
      bus_start();
      send_byte(a, 0, -1, ak);
      expect_item({"R2 address ack ", tg}, {15'h0, hit});
      observe({15'h0, ak});
      send_byte(f[15:8], gmode, gbit, ak);
      expect_item({"R3 high byte ack ", tg}, {15'h0, hit});
      observe({15'h0, ak});
      send_byte(f[7:0], gmode, gbit, ak);
      expect_item({"R3 low byte ack ", tg}, {15'h0, hit});
      observe({15'h0, ak});
      bus_stop();
      if (hit) begin
         m_in   = f;
         m_code = f[13:4];
         m_spd  = f[15];
      end
      check_outputs(tg);
   endtask

   task automatic do_read(input logic [7:0] a, input bit full, input string tg);
      bit         ak;
      logic [7:0] hb, lb;
      bus_start();
      send_byte(a, 0, -1, ak);
      expect_item({"R2 read address ack ", tg}, 16'h1);
      observe({15'h0, ak});
      recv_byte(full, hb);
      expect_item({"R6 read high byte ", tg}, {8'h0, m_in[15:8]});
      observe({8'h0, hb});
      if (full) begin
         recv_byte(1'b0, lb);
         expect_item({"R6 read low byte ", tg}, {8'h0, m_in[7:0]});
         observe({8'h0, lb});
         m_in = 16'h0;
      end else begin
         qwait();
         expect_item({"R10 released after nack ", tg}, 16'h0);
         observe({15'h0, sda_pull});
      end
      bus_stop();
      expect_item({"R7 dac code kept by read ", tg}, {6'h0, m_code});
      observe({6'h0, dac_code});
   endtask

   initial begin : driver
      bit ak;
      repeat (10) @(negedge clk);
      // R1: values held in reset and just after it
      expect_item("R1 code in reset", 16'h0);       observe({6'h0, dac_code});
      expect_item("R1 power-down in reset", 16'h0); observe({15'h0, pwr_down_eff});
      expect_item("R1 line in reset", 16'h0);       observe({15'h0, sda_pull});
      rst_n = 1'b1;
      qwait(2);
      check_outputs("R1 after reset");
      do_read(8'h19, 1'b1, "R1 empty frame");

      // R2 R4: every matching write address, distinct frames
      do_write(8'h18, 16'h5A5F, 1'b1, "R2 addr 0x18");
      do_write(8'h1A, 16'h3FF0, 1'b1, "R2 addr 0x1A");
      do_write(8'h1C, 16'h4017, 1'b1, "R2 addr 0x1C");
      do_write(8'h1E, 16'h2C3A, 1'b1, "R2 addr 0x1E");
      // R2: foreign addresses are ignored
      do_write(8'h30, 16'h1110, 1'b0, "R2 miss 0x30");
      do_write(8'h10, 16'h2220, 1'b0, "R2 miss 0x10");
      // R4: soft power-down bit and ignored bits
      do_write(8'h18, 16'hC00F, 1'b1, "R4 soft pd set");
      do_write(8'h18, 16'h4AB5, 1'b1, "R4 soft pd clear");

      // R5: stop after one data byte
      bus_start();
      send_byte(8'h18, 0, -1, ak);
      send_byte(8'hFF, 0, -1, ak);
      bus_stop();
      check_outputs("R5 stop abort");
      // R5: repeated start before the second byte completes
      bus_start();
      send_byte(8'h18, 0, -1, ak);
      send_byte(8'h81, 0, -1, ak);
      bus_start();
      send_byte(8'h30, 0, -1, ak);
      bus_stop();
      check_outputs("R5 restart abort");
      do_read(8'h1B, 1'b1, "R5 frame kept after aborts");
      // R7: frame was cleared by the read above
      do_read(8'h1D, 1'b1, "R7 cleared frame");

      // R10: nack on the first byte keeps the frame
      do_write(8'h1A, 16'h9876, 1'b1, "R10 setup");
      do_read(8'h1F, 1'b0, "R10 nack first byte");
      do_read(8'h19, 1'b1, "R10 full read after nack");

      // R8: pin path without a clock edge
      @(negedge clk);
      pd_pin = 1'b1;
      #1;
      expect_item("R8 pin raises power-down", 16'h1);
      observe({15'h0, pwr_down_eff});
      do_write(8'h18, 16'h0550, 1'b1, "R8 write under pin");
      @(negedge clk);
      pd_pin = 1'b0;
      #1;
      expect_item("R8 pin released", {15'h0, m_spd});
      observe({15'h0, pwr_down_eff});

      // R9: short spikes on each line
      do_write(8'h18, 16'h1230, 1'b1, "R9 sda spike", 1, 7);
      do_write(8'h1C, 16'h7ED0, 1'b1, "R9 scl spike", 2, 4);

      repeat (20) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_errors++;
         $display("FAIL scoreboard leftover actual %0d expected 0", exp_q.size());
      end
      finish_run();
   end
endmodule